// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives an I2C bus as master, one byte at a time, under software control through a small register bus. Software loads the target address with the direction in bit 0, then writes the control register with enable, interface enable and start generation set. The engine issues a START and sends the address byte. It then parks the bus with SCL held low and raises a status flag. Each further byte begins only when software writes zero into that flag. This status handshake is the block's only back-pressure: the bus clock does not move until software releases it.

The bus pins are open drain: `scl_oe` and `sda_oe` pull the line low when high, and the engine samples the line levels on `scl_in` and `sda_in`. Bit timing comes from `bit_tick`, a one-cycle enable produced by an external clock divider. Each bus bit takes four ticks. To end a transfer, software sets force-stop before it releases the final byte. That byte is then moved and followed by a STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0 and both bus pins are released (`scl_oe` = `sda_oe` = 0).
- R2: The address register (0x20), clock control register (0x18), interrupt enable register (0x14) and control register (0x04) read back what was written. Writing the status register (0x0C) never sets a bit, and status bit 7 always reads 0.
- R3: Writing control with bit 7 (enable), bit 3 (interface enable) and bit 0 (start generation) all set issues a START, meaning SDA falls while SCL is high. The address register byte follows, MSB first. Inside a byte, SDA changes only while SCL is low.
- R4: When the address is acknowledged, status bit 0 (address done) is set together with bit 3 (data empty) if address bit 0 is 0, or with bit 1 (data received) if it is 1. While the engine waits for software, SCL is held low.
- R5: Writing the status register clears exactly the bits written as 0 and leaves the bits written as 1 unchanged.
- R6: In a write, clearing status bit 3 sends the data register byte. When the slave acknowledges it, status bit 3 and bit 2 (data transmitted) are set.
- R7: In a read, clearing status bit 1 receives a byte MSB first and answers it with ACK. When bit 1 is set again, the data register holds that byte.
- R8: If control bit 1 (force stop) is set when a byte is released, that byte is moved and a STOP follows: SDA rises while SCL is high, then status bit 4 is set. A read byte released this way is answered with NACK.
- R9: A high SDA sample in the acknowledge slot of the address or of a written byte sets status bit 6, and the engine goes straight to STOP, ending with bit 4 set.
- R10: If the engine leaves SDA high for an address or write bit and samples it low, status bit 5 is set and both pins are released.
- R11: Writing 0 to the control register releases both pins and returns the engine to idle.
- R12: With control bits 7 and 4 set, the pins follow force bits 6 (SCL) and 5 (SDA): 1 releases the line and 0 pulls it low.
- R13: While a START, a byte or a STOP is in progress and `bit_tick` stays low, the pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr |
| bit_tick | input | 1 | Quarter-bit timing enable |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Some behaviours are checked by assertions on every cycle. Status writes must clear only the bits written as zero. SCL must stay low while the engine waits for software. SDA must move only while SCL is low inside a byte and may rise only while SCL is high at STOP. The pins must not move between ticks. Other behaviours need a scenario to show them, because the bench's slave model has to take part: that the right address and data bytes cross the bus, that a read answers ACK and then NACK, that NACK and lost-arbitration outcomes occur, and that the override and abort paths work.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned STS_W  = 7;

  localparam int unsigned OFS_CTL = 'h04;
  localparam int unsigned OFS_STS = 'h0C;
  localparam int unsigned OFS_IEN = 'h14;
  localparam int unsigned OFS_CLK = 'h18;
  localparam int unsigned OFS_ADR = 'h20;
  localparam int unsigned OFS_DAT = 'h24;

  // control bit positions
  localparam int unsigned C_EN   = 7;
  localparam int unsigned C_FSCL = 6;
  localparam int unsigned C_FSDA = 5;
  localparam int unsigned C_OVR  = 4;
  localparam int unsigned C_MIE  = 3;
  localparam int unsigned C_FSB  = 1;
  localparam int unsigned C_ESG  = 0;

  // status bit positions
  localparam int unsigned F_NAK = 6;
  localparam int unsigned F_ARB = 5;
  localparam int unsigned F_STP = 4;
  localparam int unsigned F_EMP = 3;
  localparam int unsigned F_TXD = 2;
  localparam int unsigned F_RXD = 1;
  localparam int unsigned F_ADR = 0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_BIT, PH_HOLD, PH_STOP
  } phase_e;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [STS_W-1:0]  set_flags,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              run,
  output logic              start_req,
  output logic              force_stop,
  output logic              ovr_en,
  output logic              ovr_scl,
  output logic              ovr_sda,
  output logic [BYTE_W-1:0] addr_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              flag_emp,
  output logic              flag_rxd
);
  logic [7:0]       ctl_q, ien_q, clk_q, adr_q, dat_q;
  logic [STS_W-1:0] sts_q;

  logic hit_ctl, hit_sts;
  assign hit_ctl = bus_wr && (bus_addr == AW'(OFS_CTL));
  assign hit_sts = bus_wr && (bus_addr == AW'(OFS_STS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      ien_q     <= '0;
      clk_q     <= '0;
      adr_q     <= '0;
      dat_q     <= '0;
      sts_q     <= '0;
      start_req <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          AW'(OFS_CTL): ctl_q <= bus_wdata;
          AW'(OFS_IEN): ien_q <= bus_wdata;
          AW'(OFS_CLK): clk_q <= bus_wdata;
          AW'(OFS_ADR): adr_q <= bus_wdata;
          AW'(OFS_DAT): dat_q <= bus_wdata;
          default: ;
        endcase
      end
      if (rx_load) dat_q <= rx_byte;
      sts_q <= (hit_sts ? (sts_q & bus_wdata[STS_W-1:0]) : sts_q) | set_flags;
      start_req <= hit_ctl && bus_wdata[C_EN] && bus_wdata[C_MIE] && bus_wdata[C_ESG];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_CTL): bus_rdata = ctl_q;
      AW'(OFS_STS): bus_rdata = {1'b0, sts_q};
      AW'(OFS_IEN): bus_rdata = ien_q;
      AW'(OFS_CLK): bus_rdata = clk_q;
      AW'(OFS_ADR): bus_rdata = adr_q;
      AW'(OFS_DAT): bus_rdata = dat_q;
      default: bus_rdata = '0;
    endcase
  end

  assign run        = ctl_q[C_EN] && ctl_q[C_MIE];
  assign force_stop = ctl_q[C_FSB];
  assign ovr_en     = ctl_q[C_EN] && ctl_q[C_OVR];
  assign ovr_scl    = ctl_q[C_FSCL];
  assign ovr_sda    = ctl_q[C_FSDA];
  assign addr_byte  = adr_q;
  assign tx_byte    = dat_q;
  assign flag_emp   = sts_q[F_EMP];
  assign flag_rxd   = sts_q[F_RXD];

  // R5
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_sts && set_flags == '0) |=> sts_q == ($past(sts_q) & $past(bus_wdata[STS_W-1:0])));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              run,
  input  logic              start_req,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              force_stop,
  input  logic              flag_emp,
  input  logic              flag_rxd,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic [STS_W-1:0]  set_flags,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW  = $clog2(BYTE_W + 1);
  localparam int MSB = BYTE_W - 1;

  phase_e           st;
  logic [1:0]       q;
  logic [CW-1:0]    bitn;
  logic [BYTE_W-1:0] sh;
  logic             samp, is_adr, rd, last;

  logic ack_slot, rx_mode, drv_tx, live, ev_end, ev_arb, ev_stp, nack;
  assign ack_slot = (bitn == CW'(BYTE_W));
  assign rx_mode  = rd && !is_adr;
  assign drv_tx   = !ack_slot && !rx_mode;
  assign live     = run && !start_req;
  assign ev_end   = live && st == PH_BIT && bit_tick && q == 2'd3 && ack_slot;
  assign ev_arb   = live && st == PH_BIT && bit_tick && q == 2'd3 && drv_tx && sh[MSB] && !samp;
  assign ev_stp   = live && st == PH_STOP && bit_tick && q == 2'd3;
  assign nack     = !rx_mode && samp;

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st)
      PH_START: begin scl_low = q[1]; sda_low = (q != 2'd0); end
      PH_BIT: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        sda_low = ack_slot ? (rx_mode && !last) : (drv_tx && !sh[MSB]);
      end
      PH_HOLD: scl_low = 1'b1;
      PH_STOP: begin scl_low = (q == 2'd0); sda_low = (q <= 2'd1); end
      default: ;
    endcase
  end

  always_comb begin
    set_flags        = '0;
    set_flags[F_NAK] = ev_end && nack;
    set_flags[F_ADR] = ev_end && is_adr && !nack;
    set_flags[F_EMP] = ev_end && !rx_mode && !nack && (is_adr ? !rd : !last);
    set_flags[F_TXD] = ev_end && !is_adr && !rd && !nack;
    set_flags[F_RXD] = ev_end && ((is_adr && rd && !nack) || rx_mode);
    set_flags[F_ARB] = ev_arb;
    set_flags[F_STP] = ev_stp;
  end
  assign rx_load = ev_end && rx_mode;
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_IDLE; q <= '0; bitn <= '0; sh <= '0;
      samp <= 1'b0; is_adr <= 1'b0; rd <= 1'b0; last <= 1'b0;
    end else if (!run) begin
      st <= PH_IDLE;
      q  <= '0;
    end else if (start_req) begin
      st <= PH_START; q <= '0; bitn <= '0; sh <= addr_byte;
      is_adr <= 1'b1; rd <= addr_byte[0]; last <= 1'b0;
    end else begin
      case (st)
        PH_START: if (bit_tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin st <= PH_BIT; bitn <= '0; end
        end
        PH_BIT: if (bit_tick) begin
          q <= q + 2'd1;
          if (q == 2'd2) samp <= sda_in;
          if (q == 2'd3) begin
            if (!ack_slot) begin
              sh   <= {sh[MSB-1:0], samp};
              bitn <= bitn + CW'(1);
              if (ev_arb) st <= PH_IDLE;
            end else if (nack || (!is_adr && last)) begin
              st <= PH_STOP;
            end else begin
              st <= PH_HOLD;
            end
          end
        end
        PH_HOLD: if (rd ? !flag_rxd : !flag_emp) begin
          st <= PH_BIT; q <= '0; bitn <= '0; is_adr <= 1'b0;
          sh <= rd ? '1 : tx_byte; last <= force_stop;
        end
        PH_STOP: if (bit_tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) st <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R3
  sda_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_BIT && $past(st) == PH_BIT && sda_low != $past(sda_low)) |-> (scl_low && $past(scl_low)));
  // R4
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HOLD) |-> scl_low);
  // R8
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_STOP && $past(st) == PH_STOP && !sda_low && $past(sda_low)) |-> !scl_low);
  // R13
  tick_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) inside {PH_START, PH_BIT, PH_STOP} && !$past(bit_tick) && $past(run) && !$past(start_req))
      |-> ($stable(scl_low) && $stable(sda_low)));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          bit_tick,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic              run, start_req, force_stop, ovr_en, ovr_scl, ovr_sda;
  logic              flag_emp, flag_rxd, scl_low, sda_low, rx_load;
  logic [BYTE_W-1:0] addr_byte, tx_byte, rx_byte;
  logic [STS_W-1:0]  set_flags;

  i2cm_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_flags(set_flags),
    .rx_load(rx_load), .rx_byte(rx_byte), .run(run), .start_req(start_req),
    .force_stop(force_stop), .ovr_en(ovr_en), .ovr_scl(ovr_scl), .ovr_sda(ovr_sda),
    .addr_byte(addr_byte), .tx_byte(tx_byte), .flag_emp(flag_emp), .flag_rxd(flag_rxd)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run), .start_req(start_req),
    .addr_byte(addr_byte), .tx_byte(tx_byte), .force_stop(force_stop),
    .flag_emp(flag_emp), .flag_rxd(flag_rxd), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low), .set_flags(set_flags),
    .rx_load(rx_load), .rx_byte(rx_byte)
  );

  assign scl_oe = ovr_en ? !ovr_scl : scl_low;
  assign sda_oe = ovr_en ? !ovr_sda : sda_low;

  // R4
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_emp && !run && !ovr_en) |-> !scl_oe || scl_in == 1'b0);
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int CLK_NS = 10;
  localparam logic [5:0] A_CTL = 6'h04, A_STS = 6'h0C, A_IEN = 6'h14,
                         A_CLK = 6'h18, A_ADR = 6'h20, A_DAT = 6'h24;

  logic clk = 0, rst_n = 0, bus_wr = 0, bit_tick = 0, tick_en = 1;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  wire  [7:0] bus_rdata;
  wire  scl_oe, sda_oe;
  logic pull = 0, arb_pull = 0;
  wire  scl_l = !scl_oe;
  wire  sda_l = !(sda_oe || pull || arb_pull);
  logic [1:0] tdiv = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  i2c_byte_master #(.AW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_tick(bit_tick),
    .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_NS/2) clk = !clk;
  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    bit_tick <= tick_en && (tdiv == 2'd3);
  end

  // slave model
  int sb = 0, nwr = 0, ntx = 0, n_start = 0, n_stop = 0;
  logic in_adr = 0, s_rd = 0, ack_smp = 0, nack_adr = 0, nack_dat = 0, go_tx = 0;
  logic [7:0] rsh = 0, got_adr = 0, s_tx = 0;
  logic [7:0] got_wr [4];
  logic [7:0] tx_q [2];

  always @(negedge sda_l) if (scl_l) begin sb = 0; in_adr = 1; pull = 0; n_start++; end
  always @(posedge sda_l) if (scl_l) n_stop++;
  always @(posedge scl_l) begin
    if (sb < 8) rsh = {rsh[6:0], sda_l};
    else if (sb == 8) ack_smp = sda_l;
    sb++;
  end
  always @(negedge scl_l) begin
    if (sb == 8) begin
      if (in_adr) begin got_adr = rsh; s_rd = rsh[0]; pull = !nack_adr; end
      else if (!s_rd) begin
        if (nwr < 4) got_wr[nwr] = rsh;
        nwr++; pull = !nack_dat;
      end else pull = 0;
    end else if (sb == 9) begin
      sb = 0;
      if (in_adr) begin in_adr = 0; go_tx = s_rd && !nack_adr; end
      else go_tx = s_rd && !ack_smp;
      if (go_tx) begin s_tx = tx_q[ntx & 1]; ntx++; pull = !s_tx[7]; end
      else pull = 0;
    end else if (sb >= 1 && sb <= 7 && s_rd && !in_adr) pull = !s_tx[7-sb];
  end

  task automatic slave_clear();
    sb = 0; pull = 0; nwr = 0; ntx = 0; n_start = 0; n_stop = 0;
    in_adr = 0; s_rd = 0; nack_adr = 0; nack_dat = 0; arb_pull = 0; got_adr = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_sts(input logic [7:0] m, input string tag);
    logic [7:0] s;
    bit ok = 0;
    for (int n = 0; n < 5000 && !ok; n++) begin
      rd(A_STS, s);
      if ((s & m) == m) ok = 1;
    end
    if (!ok) chk({tag, " timeout"}, s, m);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    rd(A_STS, d); chk("R1 sts", d, 0);
    rd(A_ADR, d); chk("R1 adr", d, 0);
    rd(A_DAT, d); chk("R1 dat", d, 0);
    chk("R1 pins", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_ADR, 8'hA4); rd(A_ADR, d); chk("R2 adr", d, 8'hA4);
    wr(A_CLK, 8'h3B); rd(A_CLK, d); chk("R2 clk", d, 8'h3B);
    wr(A_IEN, 8'h5E); rd(A_IEN, d); chk("R2 ien", d, 8'h5E);
    wr(A_CTL, 8'h04); rd(A_CTL, d); chk("R2 ctl", d, 8'h04);
    wr(A_STS, 8'hFF); rd(A_STS, d); chk("R2 sts", d, 8'h00);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] d;
    slave_clear();
    wr(A_ADR, 8'hA0); wr(A_CTL, 8'h89);
    wait_sts(8'h01, "R4 wr adr");
    rd(A_STS, d); chk("R4 sts after write addr", d, 8'h09);
    chk("R3 addr byte", got_adr, 8'hA0);
    chk("R3 start seen", n_start, 1);
    chk("R4 scl held", scl_oe, 1);
    wr(A_STS, 8'hFE); rd(A_STS, d); chk("R5 clear one bit", d, 8'h08);
    wr(A_DAT, 8'h3C); wr(A_CTL, 8'h88); wr(A_STS, 8'hF7);
    wait_sts(8'h08, "R6 byte1");
    rd(A_STS, d); chk("R6 sts after byte", d, 8'h0C);
    chk("R6 byte1 on bus", got_wr[0], 8'h3C);
    wr(A_DAT, 8'hC3); wr(A_CTL, 8'h8A); wr(A_STS, 8'h00);
    wait_sts(8'h10, "R8 wr stop");
    rd(A_STS, d); chk("R8 sts after write stop", d, 8'h14);
    chk("R8 last byte", got_wr[1], 8'hC3);
    chk("R8 stop seen", n_stop, 1);
    chk("R8 pins released", {scl_oe, sda_oe}, 0);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] d;
    slave_clear(); tx_q[0] = 8'h5A; tx_q[1] = 8'h96;
    wr(A_ADR, 8'hA1); wr(A_CTL, 8'h89);
    wait_sts(8'h01, "R4 rd adr");
    rd(A_STS, d); chk("R4 sts after read addr", d, 8'h03);
    chk("R3 read addr byte", got_adr, 8'hA1);
    wr(A_CTL, 8'h88); wr(A_STS, 8'h00);
    wait_sts(8'h02, "R7 byte1");
    rd(A_DAT, d); chk("R7 first rx byte", d, 8'h5A);
    chk("R7 master ack", ack_smp, 0);
    wr(A_CTL, 8'h8A); wr(A_STS, 8'h00);
    wait_sts(8'h10, "R8 rd stop");
    rd(A_DAT, d); chk("R8 last rx byte", d, 8'h96);
    chk("R8 master nack", ack_smp, 1);
    rd(A_STS, d); chk("R8 sts after read stop", d, 8'h12);
    chk("R8 read stop seen", n_stop, 1);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);
  endtask

  task automatic t_nack();
    logic [7:0] d;
    slave_clear(); nack_adr = 1;
    wr(A_ADR, 8'hA0); wr(A_CTL, 8'h89);
    wait_sts(8'h10, "R9 addr nack");
    rd(A_STS, d); chk("R9 addr nack sts", d, 8'h50);
    chk("R9 stop after addr nack", n_stop, 1);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);
    slave_clear(); nack_dat = 1;
    wr(A_ADR, 8'hA0); wr(A_CTL, 8'h89);
    wait_sts(8'h01, "R9 addr ok");
    wr(A_DAT, 8'h81); wr(A_CTL, 8'h88); wr(A_STS, 8'h00);
    wait_sts(8'h10, "R9 data nack");
    rd(A_STS, d); chk("R9 data nack sts", d, 8'h50);
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);
  endtask

  task automatic t_arb();
    logic [7:0] d;
    slave_clear(); arb_pull = 1;
    wr(A_ADR, 8'hA0); wr(A_CTL, 8'h89);
    wait_sts(8'h20, "R10 arb");
    rd(A_STS, d); chk("R10 arb sts", d, 8'h20);
    chk("R10 pins released", {scl_oe, sda_oe}, 0);
    arb_pull = 0;
    wr(A_CTL, 8'h00); wr(A_STS, 8'h00);
  endtask

  task automatic t_stall_abort();
    logic [7:0] d;
    logic [1:0] snap;
    bit same = 1;
    slave_clear();
    wr(A_ADR, 8'hA0); wr(A_CTL, 8'h89);
    repeat (60) @(negedge clk);
    tick_en = 0;
    repeat (3) @(negedge clk);
    snap = {scl_oe, sda_oe};
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if ({scl_oe, sda_oe} != snap) same = 0;
    end
    chk("R13 pins frozen without tick", same, 1);
    tick_en = 1;
    wait_sts(8'h01, "R13 resumes");
    rd(A_STS, d); chk("R13 addr done after resume", d, 8'h09);
    chk("R11 held before abort", scl_oe, 1);
    wr(A_CTL, 8'h00);
    @(negedge clk);
    chk("R11 abort releases", {scl_oe, sda_oe}, 0);
    wr(A_STS, 8'h00);
  endtask

  task automatic t_override();
    wr(A_CTL, 8'hD0); @(negedge clk);
    chk("R12 scl up sda low", {scl_oe, sda_oe}, 2'b01);
    wr(A_CTL, 8'hB0); @(negedge clk);
    chk("R12 scl low sda up", {scl_oe, sda_oe}, 2'b10);
    wr(A_CTL, 8'h90); @(negedge clk);
    chk("R12 both low", {scl_oe, sda_oe}, 2'b11);
    wr(A_CTL, 8'h00); @(negedge clk);
    chk("R11 zero control releases", {scl_oe, sda_oe}, 2'b00);
    slave_clear();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_write();
    t_read();
    t_nack();
    t_arb();
    t_stall_abort();
    t_override();
    finish_run();
  end
endmodule